// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block decides when a classic in-order pipeline takes an exception and what happens in that cycle. The decode stage can report an unknown opcode and the execute stage can report an arithmetic overflow. Each report comes with the stage's valid bit and PC. When a report is accepted, the block flushes the offending stage and every younger stage. It blocks the register write of an overflowing instruction, redirects the fetch PC to a handler and records the restart state. Older instructions in later stages are left to complete.

If both stages report in the same cycle, the execute-stage report wins because it belongs to the older instruction. The decode-stage instruction is removed by the same flush. The saved return address is the faulting PC plus 4; the handler subtracts 4 and later refetches that instruction from scratch. A parameter selects the handler entry. In fixed mode one address serves every cause. In vectored mode each cause has its own slot, and the slots are 0x20 apart.

The block carries no data stream, so there is no valid/ready pair and no back-pressure. All pins are plain control and status signals. Decisions are combinational within the cycle of the request. The saved state is registered and is read through a one-bit-indexed read port.

Top module: `exc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the saved return address and the cause bit to zero. While reset is high, no flush, write-suppress or exception take is asserted, even if requests are present.
- R2: A valid execute-stage overflow that is accepted asserts flush_if, flush_id, flush_ex and wr_suppress in the same cycle.
- R3: A valid decode-stage undefined-opcode request that is accepted with no execute-stage request asserts flush_if and flush_id only. flush_ex and wr_suppress stay low, so the older instruction completes.
- R4: When both stages request in the same cycle, the execute-stage request is taken. The cause becomes 1 and the return address is built from ex_pc.
- R5: On the clock edge that ends an accepting cycle, the saved return address becomes the taken stage's PC plus 4. It reads back through rd_sel=0 from the next cycle.
- R6: The cause bit is 0 for undefined opcode and 1 for overflow. It reads back as bit 0 of rd_data when rd_sel=1, with the upper bits 0.
- R7: With VECTORED=0, pc_target is 0x8000_0180 for every accepted exception.
- R8: With VECTORED=1, pc_target is 0xC000_0000 + 0x20 × cause: 0xC000_0000 for undefined opcode and 0xC000_0020 for overflow.
- R9: A request from a stage whose valid bit is low is ignored. It causes no flush or redirect, and the saved state does not change.
- R10: The saved return address and the cause hold their values in every cycle that does not accept an exception.
- R11: An accepted exception overrides a branch redirect in the same cycle. Without an exception, br_redirect and br_target pass to pc_redirect and pc_target.
- R12: exc_take is high for at most one cycle at a time. A request in the cycle right after an accepted one is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_undef | input | 1 | Decode stage found an undefined opcode |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| br_redirect | input | 1 | Branch unit requests a fetch redirect |
| br_target | input | 32 | Branch redirect address |
| rd_sel | input | 1 | Read select: 0 return address, 1 cause |
| exc_take | output | 1 | An exception is accepted this cycle |
| flush_if | output | 1 | Turn the fetch stage into a bubble |
| flush_id | output | 1 | Turn the decode stage into a bubble |
| flush_ex | output | 1 | Turn the execute stage into a bubble |
| wr_suppress | output | 1 | Block the execute-stage register write |
| pc_redirect | output | 1 | Next PC comes from pc_target |
| pc_target | output | 32 | Redirect address (handler or branch) |
| rd_data | output | 32 | Read data for the selected saved register |

## Verification
The flush, write-suppress, take and redirect outputs respond combinationally, so the bench drives inputs on the falling edge and compares them a few nanoseconds later in the same cycle. The return address and cause change on the next rising edge. The bench's reference model updates its copy only after that edge, and compares rd_data in the following cycle against the pre-edge state of the current one. The one-cycle block after a take is modelled as a flag set on that same edge, so back-to-back requests are scored against it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 1;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  typedef struct packed {
    logic take;
    logic from_ex;
    logic fl_if;
    logic fl_id;
    logic fl_ex;
    logic suppress;
  } exc_dec_t;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic     rst,
  input  logic     blocked,
  input  logic     id_valid,
  input  logic     id_undef,
  input  logic     ex_valid,
  input  logic     ex_ovf,
  output exc_dec_t dec
);
  logic id_req;
  logic ex_req;

  // Bubbles cannot raise requests
  assign id_req = id_valid & id_undef;
  assign ex_req = ex_valid & ex_ovf;

  always_comb begin
    dec          = '0;
    dec.take     = (id_req | ex_req) & ~blocked & ~rst;
    // Deepest stage is the oldest instruction and wins
    dec.from_ex  = ex_req;
    dec.fl_if    = dec.take;
    dec.fl_id    = dec.take;
    dec.fl_ex    = dec.take & ex_req;
    dec.suppress = dec.take & ex_req;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter bit              VECTORED    = 1'b0,
  parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
  parameter int              SLOT_SHIFT  = 5
)(
  input  cause_e          cause,
  output logic [XLEN-1:0] entry
);
  logic [XLEN-1:0] slot_addr;

  assign slot_addr = VEC_BASE + (XLEN'(cause) << SLOT_SHIFT);
  assign entry     = VECTORED ? slot_addr : FIXED_ENTRY;
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  cause_e          cause_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic            rd_sel,
  output logic [XLEN-1:0] rd_data,
  output logic            taken_q
);
  logic [XLEN-1:0] epc_q;
  cause_e          cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (take) begin
        epc_q   <= pc_in + XLEN'(4);
        cause_q <= cause_in;
      end
    end
  end

  assign rd_data = rd_sel ? {{(XLEN-CAUSE_W){1'b0}}, cause_q} : epc_q;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter bit VECTORED = 1'b0
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        id_valid,
  input  logic        id_undef,
  input  logic [31:0] id_pc,
  input  logic        ex_valid,
  input  logic        ex_ovf,
  input  logic [31:0] ex_pc,
  input  logic        br_redirect,
  input  logic [31:0] br_target,
  input  logic        rd_sel,
  output logic        exc_take,
  output logic        flush_if,
  output logic        flush_id,
  output logic        flush_ex,
  output logic        wr_suppress,
  output logic        pc_redirect,
  output logic [31:0] pc_target,
  output logic [31:0] rd_data
);
  exc_dec_t        dec;
  logic            taken_q;
  cause_e          cause_sel;
  logic [XLEN-1:0] pc_sel;
  logic [XLEN-1:0] entry;

  exc_prio u_prio (
    .rst      (rst),
    .blocked  (taken_q),
    .id_valid (id_valid),
    .id_undef (id_undef),
    .ex_valid (ex_valid),
    .ex_ovf   (ex_ovf),
    .dec      (dec)
  );

  assign cause_sel = dec.from_ex ? CAUSE_OVF : CAUSE_UNDEF;
  assign pc_sel    = dec.from_ex ? ex_pc : id_pc;

  exc_vector #(.VECTORED(VECTORED)) u_vec (
    .cause (cause_sel),
    .entry (entry)
  );

  exc_state u_state (
    .clk      (clk),
    .rst      (rst),
    .take     (dec.take),
    .cause_in (cause_sel),
    .pc_in    (pc_sel),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .taken_q  (taken_q)
  );

  assign exc_take    = dec.take;
  assign flush_if    = dec.fl_if;
  assign flush_id    = dec.fl_id;
  assign flush_ex    = dec.fl_ex;
  assign wr_suppress = dec.suppress;
  // Exception redirect outranks a branch in the same cycle
  assign pc_redirect = dec.take | (br_redirect & ~rst);
  assign pc_target   = dec.take ? entry : br_target;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        id_valid,
  input logic        id_undef,
  input logic        ex_valid,
  input logic        ex_ovf,
  input logic [31:0] ex_pc,
  input logic        exc_take,
  input logic        flush_if,
  input logic        flush_id,
  input logic        flush_ex,
  input logic        wr_suppress,
  input logic        pc_redirect,
  input logic [31:0] epc_q
);
  // R2: a write suppress always comes with a flush of the execute stage
  p_ovf_suppress_r2: assert property (@(posedge clk) disable iff (rst)
    wr_suppress |-> (flush_ex && flush_id && flush_if));

  // R3: flushing the execute stage implies flushing all younger stages
  p_flush_order_r3: assert property (@(posedge clk) disable iff (rst)
    flush_ex |-> (flush_id && flush_if));

  // R5: return address is the execute-stage PC plus 4 after an overflow take
  p_epc_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_take && ex_valid && ex_ovf) |=> (epc_q == $past(ex_pc) + 32'd4));

  // R9: no valid request, no take
  p_bubble_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!(ex_valid && ex_ovf) && !(id_valid && id_undef)) |-> !exc_take);

  // R10: saved address holds without a take
  p_epc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !exc_take |=> $stable(epc_q));

  // R11: a take always redirects fetch
  p_take_redirect_r11: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> pc_redirect);

  // R12: take never lasts two cycles
  p_take_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> !exc_take);
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .id_valid    (id_valid),
  .id_undef    (id_undef),
  .ex_valid    (ex_valid),
  .ex_ovf      (ex_ovf),
  .ex_pc       (ex_pc),
  .exc_take    (exc_take),
  .flush_if    (flush_if),
  .flush_id    (flush_id),
  .flush_ex    (flush_ex),
  .wr_suppress (wr_suppress),
  .pc_redirect (pc_redirect),
  .epc_q       (u_state.epc_q)
);

// File: tb/exc_ctrl_bench.sv
`timescale 1ns/1ps
module exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid, id_undef, ex_valid, ex_ovf, br_redirect, rd_sel;
  logic [31:0] id_pc, ex_pc, br_target;
  logic        exc_take, flush_if, flush_id, flush_ex, wr_suppress, pc_redirect;
  logic [31:0] pc_target, rd_data;
  logic        v_take, v_fif, v_fid, v_fex, v_sup, v_redir;
  logic [31:0] v_target, v_rd;

  always #10 clk = ~clk;

  exc_ctrl #(.VECTORED(1'b0)) u_exc_ctrl (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .br_redirect(br_redirect),
    .br_target(br_target), .rd_sel(rd_sel), .exc_take(exc_take), .flush_if(flush_if),
    .flush_id(flush_id), .flush_ex(flush_ex), .wr_suppress(wr_suppress),
    .pc_redirect(pc_redirect), .pc_target(pc_target), .rd_data(rd_data));

  exc_ctrl #(.VECTORED(1'b1)) u_exc_ctrl_vec (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .br_redirect(br_redirect),
    .br_target(br_target), .rd_sel(rd_sel), .exc_take(v_take), .flush_if(v_fif),
    .flush_id(v_fid), .flush_ex(v_fex), .wr_suppress(v_sup),
    .pc_redirect(v_redir), .pc_target(v_target), .rd_data(v_rd));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  logic [31:0] m_epc   = '0;
  logic        m_cause = 1'b0;
  logic        m_taken = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic accept(input logic iv, input logic iu, input logic ev,
                                  input logic eo, input logic blk);
    return ((iv & iu) | (ev & eo)) & ~blk;
  endfunction

  function automatic logic [31:0] vec_entry(input logic cause);
    return 32'hC000_0000 + (cause ? 32'h20 : 32'h0);
  endfunction

  task automatic drive(input logic iv, input logic iu, input logic [31:0] ipc,
                       input logic ev, input logic eo, input logic [31:0] epc,
                       input logic bv, input logic [31:0] bt, input logic sel);
    id_valid = iv; id_undef = iu; id_pc = ipc;
    ex_valid = ev; ex_ovf = eo; ex_pc = epc;
    br_redirect = bv; br_target = bt; rd_sel = sel;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic cycle(input string tag);
    logic acc, fex;
    #3;
    acc = accept(id_valid, id_undef, ex_valid, ex_ovf, m_taken);
    fex = ex_valid & ex_ovf;
    chk(tag, "exc_take", {31'b0, exc_take}, {31'b0, acc});
    chk(tag, "flush_if", {31'b0, flush_if}, {31'b0, acc});
    chk(tag, "flush_id", {31'b0, flush_id}, {31'b0, acc});
    chk(tag, "flush_ex", {31'b0, flush_ex}, {31'b0, acc & fex});
    chk(tag, "wr_suppress", {31'b0, wr_suppress}, {31'b0, acc & fex});
    chk(tag, "pc_redirect", {31'b0, pc_redirect}, {31'b0, acc | br_redirect});
    chk(acc ? "R7" : "R11", "pc_target", pc_target, acc ? 32'h8000_0180 : br_target);
    chk(acc ? "R8" : "R11", "vec pc_target", v_target, acc ? vec_entry(fex) : br_target);
    chk(rd_sel ? "R6" : "R5", "rd_data", rd_data, rd_sel ? {31'b0, m_cause} : m_epc);
    @(posedge clk);
    if (acc) begin
      m_epc   = (fex ? ex_pc : id_pc) + 32'd4;
      m_cause = fex;
    end
    m_taken = acc;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    drive(1, 1, 32'h100, 1, 1, 32'h200, 1, 32'h300, 0);
    @(negedge clk); @(negedge clk);
    #3;
    // R1: requests ignored in reset
    chk("R1", "exc_take in reset", {31'b0, exc_take}, 32'd0);
    chk("R1", "flush_if in reset", {31'b0, flush_if}, 32'd0);
    chk("R1", "wr_suppress in reset", {31'b0, wr_suppress}, 32'd0);
    chk("R1", "epc after reset", rd_data, 32'd0);
    rd_sel = 1'b1; #1;
    chk("R1", "cause after reset", rd_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R1");

    // R3: decode only, older execute instruction completes
    drive(1, 1, 32'h0000_1000, 1, 0, 32'h0000_0ffc, 0, 0, 0);
    cycle("R3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cycle("R6");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R5");

    // R2/R4: simultaneous, execute wins; branch also present (R11)
    drive(1, 1, 32'h0000_0050, 1, 1, 32'h0000_004c, 1, 32'h0000_9000, 0);
    cycle("R4");
    // R12: request right after a take is blocked
    drive(1, 1, 32'h0000_0060, 1, 1, 32'h0000_0064, 0, 0, 0);
    cycle("R12");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cycle("R4");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R5");

    // R9: requests from bubbles
    drive(0, 1, 32'h0000_7000, 0, 1, 32'h0000_7004, 0, 0, 0);
    cycle("R9");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R10");

    // R11: branch alone passes through
    drive(0, 0, 0, 1, 0, 32'h40, 1, 32'h0000_abcc, 1);
    cycle("R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 6) == 0, $urandom & 32'hffff_fffc,
            ($urandom % 4) != 0, ($urandom % 7) == 0, $urandom & 32'hffff_fffc,
            ($urandom % 5) == 0, $urandom & 32'hffff_fffc, 1'($urandom));
      cycle("R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule